// File: doc/BRIEF.md
# Cartridge Byte-Order Normalizer

This block sits in the load path of a cartridge image and turns a stream of 32-bit words, as they come out of storage, into a stream of big-endian words. An image can be stored in one of three layouts: big endian, fully reversed little endian, or with the two bytes of each 16-bit half exchanged. The block reads the marker byte at the start of the image, which is a known constant, to work out which layout was used. It then applies the matching byte permutation to every word of that image, and the first word is permuted too.

Both sides use a valid/ready handshake. One register stage sits between them, so a word accepted on a clock edge is presented at the output from that same edge. A one-cycle start-of-image strobe clears the locked layout so that the next image is classified afresh. The strobe may coincide with the first word of the new image. If the marker byte is not one of the three known values, the block raises a flag and passes the words through unchanged.

Top module: `cart_order_norm`

## Requirements
- R1: After reset, `out_valid` and `bad_marker` are 0 and `in_ready` is 1.
- R2: The marker is bits [31:24] of the first word accepted in an image. A marker of 0x80 means big endian, and every word of the image leaves unchanged.
- R3: A marker of 0x37 means half-swapped. Each output word is {in[23:16], in[31:24], in[7:0], in[15:8]}.
- R4: A marker of 0x40 means little endian. Each output word is {in[7:0], in[15:8], in[23:16], in[31:24]}.
- R5: The permutation selected by the marker is also applied to the first word, which carries the marker.
- R6: The layout is locked for the rest of the image. Later words whose bits [31:24] equal some other marker value do not change it.
- R7: A cycle with `img_start` high clears the locked layout and `bad_marker`. The next accepted word, or a word accepted in that same cycle, is then classified as the first word of a new image.
- R8: Any other marker value sets `bad_marker` together with the first word at the output, and the image passes through unchanged. `bad_marker` stays at 1 until `img_start`.
- R9: A word accepted on an edge appears on `out_data` with `out_valid` high right after that edge. There is one register stage of latency.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` holds and `in_ready` is 0. No word is dropped, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| img_start | input | 1 | Start-of-image strobe; clears the locked layout |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept an input word |
| in_data | input | 32 | Input word in storage order; bits [31:24] are the lowest address |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | 32 | Word in big-endian order |
| bad_marker | output | 1 | Marker of the current image was not recognised |

## Verification
The assertions assume that the source holds `in_data` steady and that `img_start` is a cycle-level strobe. They also assume that the consumer drains the output stage before a new image begins, because the strobe clears `bad_marker` straight away. The stimulus therefore raises `img_start` only while the first word of an image is on offer and the output stage is empty. Inside each image, valid and ready are toggled at random on both sides, and words whose top byte equals another marker value are sprinkled in.

// File: rtl/cbo_pkg.sv
package cbo_pkg;
  typedef enum logic [2:0] {
    ORD_PEND    = 3'd0,
    ORD_BIG     = 3'd1,
    ORD_SWAP    = 3'd2,
    ORD_LITTLE  = 3'd3,
    ORD_UNKNOWN = 3'd4
  } order_e;
endpackage

// File: rtl/cbo_classifier.sv
module cbo_classifier
  import cbo_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter logic [LANE_W-1:0] MARK_BIG    = 8'h80,
  parameter logic [LANE_W-1:0] MARK_SWAP   = 8'h37,
  parameter logic [LANE_W-1:0] MARK_LITTLE = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              img_start,
  input  logic              accept,
  input  logic [LANE_W-1:0] marker,
  output order_e            word_order,
  output logic              bad_q
);
  logic   pending_q;
  logic   pending_eff;
  order_e order_q;
  order_e decoded;

  always_comb begin
    if (marker == MARK_BIG)         decoded = ORD_BIG;
    else if (marker == MARK_SWAP)   decoded = ORD_SWAP;
    else if (marker == MARK_LITTLE) decoded = ORD_LITTLE;
    else                            decoded = ORD_UNKNOWN;
  end

  assign pending_eff = pending_q | img_start;
  assign word_order  = pending_eff ? decoded : order_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b1;
      order_q   <= ORD_PEND;
      bad_q     <= 1'b0;
    end else if (accept && pending_eff) begin
      pending_q <= 1'b0;
      order_q   <= decoded;
      bad_q     <= (decoded == ORD_UNKNOWN);
    end else if (img_start) begin
      pending_q <= 1'b1;
      order_q   <= ORD_PEND;
      bad_q     <= 1'b0;
    end
  end

  // R6: a locked layout holds while no new image begins
  a_r6_order_locked: assert property (@(posedge clk) disable iff (rst)
    (!pending_q && !img_start) |=> $stable(order_q));

  // R8: the flag only ever accompanies an unrecognised layout
  a_r8_flag_unknown: assert property (@(posedge clk) disable iff (rst)
    bad_q |-> (order_q == ORD_UNKNOWN));

  // R7: a strobe without a word re-arms classification and clears the flag
  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    (img_start && !accept) |=> (pending_q && !bad_q));
endmodule

// File: rtl/cbo_permute.sv
module cbo_permute
  import cbo_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int W = LANE_W * LANES
) (
  input  order_e       mode,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] swp;
  logic [W-1:0] rev;

  // lane k occupies bits [W-1-k*LANE_W -: LANE_W]; lane 0 is the lowest address
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign swp[W-1-g*LANE_W -: LANE_W] = din[W-1-(g^1)*LANE_W -: LANE_W];
    assign rev[W-1-g*LANE_W -: LANE_W] = din[(g+1)*LANE_W-1 -: LANE_W];
  end

  always_comb begin
    case (mode)
      ORD_SWAP:   dout = swp;
      ORD_LITTLE: dout = rev;
      default:    dout = din;
    endcase
  end
endmodule

// File: rtl/cbo_stage.sv
module cbo_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         v_q;
  logic [W-1:0] d_q;

  assign in_ready  = !v_q || out_ready;
  assign out_valid = v_q;
  assign out_data  = d_q;

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else if (in_ready) v_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) d_q <= in_data;
  end

  // R10: a stalled word stays put
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9: an accepted word is presented after one edge
  a_r9_fill: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/cart_order_norm.sv
module cart_order_norm
  import cbo_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  parameter logic [LANE_W-1:0] MARK_BIG    = 8'h80,
  parameter logic [LANE_W-1:0] MARK_SWAP   = 8'h37,
  parameter logic [LANE_W-1:0] MARK_LITTLE = 8'h40,
  localparam int W = LANE_W * LANES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         img_start,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         bad_marker
);
  order_e       word_order;
  logic [W-1:0] norm_word;
  logic         accept;

  assign accept = in_valid && in_ready;

  cbo_classifier #(
    .LANE_W(LANE_W), .MARK_BIG(MARK_BIG),
    .MARK_SWAP(MARK_SWAP), .MARK_LITTLE(MARK_LITTLE)
  ) u_class (
    .clk(clk), .rst(rst), .img_start(img_start), .accept(accept),
    .marker(in_data[W-1 -: LANE_W]), .word_order(word_order), .bad_q(bad_marker)
  );

  cbo_permute #(.LANE_W(LANE_W), .LANES(LANES)) u_perm (
    .mode(word_order), .din(in_data), .dout(norm_word)
  );

  cbo_stage #(.W(W)) u_stage (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(norm_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  // R10: a full, stalled stage refuses input
  a_r10_no_drop: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R1: empty after reset
  a_r1_reset_empty: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !bad_marker));
endmodule

// File: tb/tb_cart_order_norm.sv
`timescale 1ns/1ps
module tb_cart_order_norm;
  logic        clk = 1'b0;
  logic        rst;
  logic        img_start;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;
  logic        bad_marker;

  int n_chk = 0;
  int n_err = 0;
  int n_push = 0;
  int n_pop = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  bit          expb_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  cart_order_norm dut (
    .clk(clk), .rst(rst), .img_start(img_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .bad_marker(bad_marker)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] perm(input logic [31:0] w, input int kind);
    case (kind)
      1: return {w[23:16], w[31:24], w[7:0], w[15:8]};
      2: return {w[7:0], w[15:8], w[23:16], w[31:24]};
      default: return w;
    endcase
  endfunction

  function automatic logic [7:0] marker_of(input int kind);
    logic [7:0] m;
    case (kind)
      0: m = 8'h80;
      1: m = 8'h37;
      2: m = 8'h40;
      default: begin
        m = 8'($urandom);
        while (m == 8'h80 || m == 8'h37 || m == 8'h40) m = 8'($urandom);
      end
    endcase
    return m;
  endfunction

  function automatic string kind_tag(input int kind);
    case (kind)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic step(input bit iv, input logic [31:0] d, input logic [31:0] ew,
                      input bit eb, input string tag, input bit ordy, input bit st,
                      output bit acc);
    @(negedge clk);
    in_valid = iv; in_data = d; out_ready = ordy; img_start = st;
    #1;
    if (out_valid && out_ready) begin
      n_pop++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected word", out_data, 32'h0);
      end else begin
        logic [31:0] e = exp_q.pop_front();
        bit b = expb_q.pop_front();
        string t = tag_q.pop_front();
        check(out_data === e, t, out_data, e);
        check(bad_marker === b, "R8 flag", {31'd0, bad_marker}, {31'd0, b});
      end
    end
    acc = iv && in_ready;
    if (acc) begin
      n_push++;
      exp_q.push_back(ew); expb_q.push_back(eb); tag_q.push_back(tag);
    end
  endtask

  task automatic drain();
    bit acc;
    for (int i = 0; i < 8; i++) step(1'b0, 32'h0, 32'h0, 1'b0, "", 1'b1, 1'b0, acc);
  endtask

  task automatic send_word(input logic [31:0] d, input int kind, input string tag, input bit st);
    bit acc = 0;
    while (!acc) begin
      bit iv = ($urandom % 4) != 0;
      bit rd = ($urandom % 3) != 0;
      step(iv, d, perm(d, kind), kind == 3, tag, rd, st, acc);
    end
  endtask

  task automatic run_image(input int kind, input int len, input bit stray);
    drain();
    for (int i = 0; i < len; i++) begin
      logic [31:0] w = $urandom;
      if (i == 0) w[31:24] = marker_of(kind);
      else if (stray && ($urandom % 3) == 0) w[31:24] = marker_of($urandom % 3);
      send_word(w, kind,
                i == 0 ? $sformatf("R5 %s", kind_tag(kind)) : $sformatf("R6 %s", kind_tag(kind)),
                i == 0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    bit acc;
    void'($urandom(32'd1234));
    rst = 1; img_start = 0; in_valid = 0; in_data = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1
    check(out_valid === 1'b0, "R1 out_valid", {31'd0, out_valid}, 32'd0);
    check(bad_marker === 1'b0, "R1 bad_marker", {31'd0, bad_marker}, 32'd0);
    check(in_ready === 1'b1, "R1 in_ready", {31'd0, in_ready}, 32'd1);

    // R9 and R10 directed, big-endian first word
    @(negedge clk);
    in_valid = 1; in_data = 32'h80AABBCC; img_start = 1; out_ready = 0;
    #1 check(in_ready === 1'b1, "R9 accept", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 0; img_start = 0;
    #1;
    check(out_valid === 1'b1, "R9 latency", {31'd0, out_valid}, 32'd1);
    check(out_data === 32'h80AABBCC, "R9 R2 data", out_data, 32'h80AABBCC);
    check(in_ready === 1'b0, "R10 stall ready", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    #1 check(out_data === 32'h80AABBCC, "R10 hold", out_data, 32'h80AABBCC);
    out_ready = 1;
    #1 check(in_ready === 1'b1, "R10 ready follows", {31'd0, in_ready}, 32'd1);
    drain();

    // R5 little-endian first word, then R6 with stray markers
    send_word(32'h40112233, 2, "R5 R4 first", 1'b1);
    send_word(32'h80445566, 2, "R6 R4 stray", 1'b0);
    send_word(32'h37778899, 2, "R6 R4 stray", 1'b0);
    drain();
    send_word(32'h37A1B2C3, 1, "R5 R3 first", 1'b1);
    send_word(32'h40D4E5F6, 1, "R6 R3 stray", 1'b0);
    drain();

    // R8 unknown marker, then R7 strobe alone clears the flag
    run_image(3, 5, 1'b1);
    drain();
    #1 check(bad_marker === 1'b1, "R8 flag holds", {31'd0, bad_marker}, 32'd1);
    step(1'b0, 32'h0, 32'h0, 1'b0, "", 1'b1, 1'b1, acc);
    step(1'b0, 32'h0, 32'h0, 1'b0, "", 1'b1, 1'b0, acc);
    check(bad_marker === 1'b0, "R7 strobe clears", {31'd0, bad_marker}, 32'd0);
    run_image(0, 4, 1'b1);

    // random images
    for (int k = 0; k < 40; k++) begin
      int kind = (($urandom % 8) == 0) ? 3 : int'($urandom % 3);
      run_image(kind, 1 + ($urandom % 24), 1'b1);
    end
    drain();

    check(exp_q.size() == 0, "R10 leftover words", 32'(exp_q.size()), 32'd0);
    check(n_push == n_pop, "R10 transfer count", 32'(n_pop), 32'(n_push));
    finish_run();
  end
endmodule